// File: doc/BRIEF.md
# TCP/IP Transmit Header Generator

The block produces the complete 54-byte Ethernet, IPv4 and TCP header for each outgoing data segment of one established connection. The fields that stay fixed for the life of the connection (addresses, ports, type of service, time to live) are loaded once into a template. The per-packet fields are computed in hardware: sequence number, IP identification, lengths, TCP flags, and both checksums.

A send request gives a byte count, an acknowledgement number, a window and a flag byte. The block cuts the request into segments of at most `MSS` bytes. For each segment it accepts the payload as 64-bit words and adds the payload into a running ones'-complement sum as the words arrive. After the last word it adds the pseudo-header and header terms, registers the finished header, and raises a one-cycle done pulse. No second pass over the data is needed. The next segment follows until the request has been sent in full. The surrounding fetch engine supplies payload words while `pay_ready_o` is high and picks up `hdr_o` on `done_o`.

Top module: `tx_hdr_gen`

## Requirements
- R1: While `busy_o` is low, a high `tpl_load_i` captures the MAC addresses, IP addresses, ports, type of service, TTL, starting sequence number and starting IP identification. Every later header carries the captured constant fields unchanged. A load while `busy_o` is high is ignored.
- R2: A request is accepted when `req_valid_i` is high, `busy_o` is low and `req_len_i` is non-zero. The request is sent as full `MSS`-byte segments (default 1448) followed by one segment for the remainder. A request of `MSS` bytes or fewer is sent as one segment. A request of length 0 is ignored.
- R3: The first segment after a template load uses the loaded sequence number and identification. Each later segment advances the sequence number by the previous segment's byte count (modulo 2^32) and the identification by one (modulo 2^16).
- R4: For a segment of L bytes, the IP total length field is 40+L and `frame_len_o` is 54+L.
- R5: The TCP checksum is the inverted 16-bit ones'-complement sum (end-around carry) of these terms: source and destination IP, the word 0x0006, the TCP length 20+L, the TCP header with its checksum field zero, and the payload. An odd payload length is padded with one zero byte. Bytes of the last payload word that lie beyond L do not affect the result.
- R6: The IP header checksum is the inverted ones'-complement sum of the ten 16-bit words of the IP header, taken with its checksum field zero.
- R7: The acknowledgement number and window come from the request. The TCP flag byte equals the request's flags except for bit 3 (0x08, push), which is set on the final segment of a request and cleared on every earlier one.
- R8: `done_o` pulses for one cycle, in the cycle after the first clock edge that follows the edge accepting a segment's last payload word. `hdr_o` and `frame_len_o` change only together with that pulse and hold their value otherwise. All outputs are zero after reset.
- R9: `busy_o` rises in the cycle after a request is accepted. It falls in the cycle that `done_o` reports the final segment. Requests made while it is high are ignored.
- R10: `pay_ready_o` is high exactly while the current segment still expects payload words. A word is consumed on a clock edge where `pay_valid_i` and `pay_ready_o` are both high. Words offered while `pay_ready_o` is low are ignored.
- R11: `hdr_o` holds the header with byte 0 in bits 431:424. The byte order is as follows:
  - destination MAC, source MAC, type 0x0800;
  - 0x45, type of service, total length, identification, 0x4000, TTL, protocol 6, IP checksum, source IP, destination IP;
  - source port, destination port, sequence, acknowledgement, 0x50, flags, window, TCP checksum, 0x0000.

  Multi-byte fields are big-endian. Payload byte 0 of each word is bits 63:56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tpl_load_i | input | 1 | Capture the connection template |
| tpl_dst_mac_i | input | 48 | Destination MAC address |
| tpl_src_mac_i | input | 48 | Source MAC address |
| tpl_src_ip_i | input | 32 | Source IPv4 address |
| tpl_dst_ip_i | input | 32 | Destination IPv4 address |
| tpl_src_port_i | input | 16 | TCP source port |
| tpl_dst_port_i | input | 16 | TCP destination port |
| tpl_tos_i | input | 8 | IP type of service |
| tpl_ttl_i | input | 8 | IP time to live |
| tpl_seq_i | input | 32 | Starting sequence number |
| tpl_ip_id_i | input | 16 | Starting IP identification |
| req_valid_i | input | 1 | Send request strobe |
| req_len_i | input | LEN_W | Request length in bytes |
| req_ack_i | input | 32 | Acknowledgement number |
| req_win_i | input | 16 | Advertised window |
| req_flags_i | input | 8 | TCP flag byte |
| pay_valid_i | input | 1 | Payload word valid |
| pay_data_i | input | DATA_W | Payload word, first byte in the top bits |
| busy_o | output | 1 | Request in progress |
| pay_ready_o | output | 1 | Payload word expected |
| done_o | output | 1 | Header complete, one cycle |
| hdr_o | output | 432 | Finished header |
| frame_len_o | output | 16 | Frame length without FCS |

## Verification
The last payload word of a segment is consumed on edge k. The finishing cycle then runs with `pay_ready_o` low and `done_o` still low, which the bench checks at the falling edge after k. On edge k+1 the header, the frame length and the done pulse are registered together with the advanced sequence number and identification. The bench therefore compares the header fields, the checksums, `frame_len_o` and `busy_o` at the falling edge after k+1. It confirms that `done_o` is low again one cycle later. Busy is checked one cycle after each request strobe, and ignored stimulus (zero length, requests and loads during busy, stray payload) is judged through the headers that follow.

// File: rtl/tx_hdr_pkg.sv
package tx_hdr_pkg;
  localparam int unsigned HDR_BYTES = 54;
  localparam int unsigned HDR_W     = HDR_BYTES * 8;

  typedef struct packed {
    logic [47:0] dst_mac;
    logic [47:0] src_mac;
    logic [31:0] src_ip;
    logic [31:0] dst_ip;
    logic [15:0] src_port;
    logic [15:0] dst_port;
    logic [7:0]  tos;
    logic [7:0]  ttl;
  } conn_tpl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PAY  = 2'd1,
    ST_FIN  = 2'd2
  } seg_state_e;

  // 32-bit sum -> 16-bit ones' complement value
  function automatic logic [15:0] oc_fold(input logic [31:0] s);
    logic [16:0] t;
    t = {1'b0, s[15:0]} + {1'b0, s[31:16]};
    t = {1'b0, t[15:0]} + {16'd0, t[16]};
    return t[15:0];
  endfunction
endpackage

// File: rtl/tx_hdr_csum_acc.sv
module tx_hdr_csum_acc #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ACC_W  = 32,
  localparam int unsigned NBYTES = DATA_W / 8,
  localparam int unsigned NB_W   = $clog2(NBYTES + 1),
  localparam int unsigned LANES  = DATA_W / 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [NB_W-1:0]   nbytes_i,
  output logic [ACC_W-1:0]  acc_o
);
  logic [DATA_W-1:0] masked;
  logic [ACC_W-1:0]  word_sum;

  for (genvar b = 0; b < NBYTES; b++) begin : g_mask
    assign masked[DATA_W-1-8*b -: 8] =
      (NB_W'(b) < nbytes_i) ? data_i[DATA_W-1-8*b -: 8] : 8'h00;
  end

  always_comb begin
    word_sum = '0;
    for (int l = 0; l < LANES; l++) begin
      word_sum = word_sum + ACC_W'(masked[DATA_W-1-16*l -: 16]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_o <= '0;
    else if (clear_i) acc_o <= '0;
    else if (add_i)   acc_o <= acc_o + word_sum;
  end
endmodule

// File: rtl/tx_hdr_seg_ctrl.sv
module tx_hdr_seg_ctrl
  import tx_hdr_pkg::*;
#(
  parameter int unsigned LEN_W  = 20,
  parameter int unsigned MSS    = 1448,
  parameter int unsigned NBYTES = 8,
  localparam int unsigned SEG_W = $clog2(MSS + 1),
  localparam int unsigned NB_W  = $clog2(NBYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic             pay_valid_i,
  output logic             start_o,
  output logic             take_o,
  output logic             fire_o,
  output logic             last_o,
  output logic             acc_clear_o,
  output logic [NB_W-1:0]  nbytes_o,
  output logic [SEG_W-1:0] seg_len_o,
  output logic             busy_o,
  output logic             pay_ready_o
);
  seg_state_e       state_q;
  logic [LEN_W-1:0] rem_q;
  logic [SEG_W-1:0] left_q;
  logic [LEN_W-1:0] first_len, next_len;

  assign first_len = (req_len_i > LEN_W'(MSS)) ? LEN_W'(MSS) : req_len_i;
  assign next_len  = (rem_q > LEN_W'(MSS)) ? LEN_W'(MSS) : rem_q;

  assign start_o     = (state_q == ST_IDLE) && req_valid_i && (req_len_i != '0);
  assign take_o      = (state_q == ST_PAY) && pay_valid_i;
  assign fire_o      = (state_q == ST_FIN);
  assign last_o      = (rem_q == '0);
  assign acc_clear_o = start_o || fire_o;
  assign nbytes_o    = (left_q >= SEG_W'(NBYTES)) ? NB_W'(NBYTES) : NB_W'(left_q);
  assign busy_o      = (state_q != ST_IDLE);
  assign pay_ready_o = (state_q == ST_PAY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rem_q     <= '0;
      left_q    <= '0;
      seg_len_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_o) begin
          seg_len_o <= SEG_W'(first_len);
          left_q    <= SEG_W'(first_len);
          rem_q     <= req_len_i - first_len;
          state_q   <= ST_PAY;
        end
        ST_PAY: if (take_o) begin
          left_q <= left_q - SEG_W'(nbytes_o);
          if (left_q <= SEG_W'(NBYTES)) state_q <= ST_FIN;
        end
        ST_FIN: begin
          if (rem_q != '0) begin
            seg_len_o <= SEG_W'(next_len);
            left_q    <= SEG_W'(next_len);
            rem_q     <= rem_q - next_len;
            state_q   <= ST_PAY;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_hdr_build.sv
module tx_hdr_build
  import tx_hdr_pkg::*;
#(
  parameter int unsigned SEG_W = 11
) (
  input  conn_tpl_t        tpl_i,
  input  logic [31:0]      seq_i,
  input  logic [31:0]      ack_i,
  input  logic [15:0]      id_i,
  input  logic [15:0]      win_i,
  input  logic [7:0]       flags_i,
  input  logic [SEG_W-1:0] seg_len_i,
  input  logic [31:0]      pay_sum_i,
  output logic [HDR_W-1:0] hdr_o,
  output logic [15:0]      frame_len_o
);
  logic [15:0] ip_tot, tcp_len, ip_ck, tcp_ck;
  logic [31:0] ip_sum, tcp_sum;

  always_comb begin
    ip_tot      = 16'd40 + 16'(seg_len_i);
    tcp_len     = 16'd20 + 16'(seg_len_i);
    frame_len_o = 16'd54 + 16'(seg_len_i);

    ip_sum = 32'({8'h45, tpl_i.tos}) + 32'(ip_tot) + 32'(id_i) + 32'h4000
           + 32'({tpl_i.ttl, 8'h06})
           + 32'(tpl_i.src_ip[31:16]) + 32'(tpl_i.src_ip[15:0])
           + 32'(tpl_i.dst_ip[31:16]) + 32'(tpl_i.dst_ip[15:0]);
    ip_ck = ~oc_fold(ip_sum);

    tcp_sum = 32'(tpl_i.src_ip[31:16]) + 32'(tpl_i.src_ip[15:0])
            + 32'(tpl_i.dst_ip[31:16]) + 32'(tpl_i.dst_ip[15:0])
            + 32'h0006 + 32'(tcp_len)
            + 32'(tpl_i.src_port) + 32'(tpl_i.dst_port)
            + 32'(seq_i[31:16]) + 32'(seq_i[15:0])
            + 32'(ack_i[31:16]) + 32'(ack_i[15:0])
            + 32'({8'h50, flags_i}) + 32'(win_i)
            + 32'(oc_fold(pay_sum_i));
    tcp_ck = ~oc_fold(tcp_sum);

    hdr_o = {tpl_i.dst_mac, tpl_i.src_mac, 16'h0800,
             8'h45, tpl_i.tos, ip_tot, id_i, 16'h4000, tpl_i.ttl, 8'h06, ip_ck,
             tpl_i.src_ip, tpl_i.dst_ip,
             tpl_i.src_port, tpl_i.dst_port, seq_i, ack_i,
             8'h50, flags_i, win_i, tcp_ck, 16'h0000};
  end
endmodule

// File: rtl/tx_hdr_gen.sv
module tx_hdr_gen
  import tx_hdr_pkg::*;
#(
  parameter int unsigned MSS    = 1448,
  parameter int unsigned LEN_W  = 20,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned SEG_W  = $clog2(MSS + 1),
  localparam int unsigned NBYTES = DATA_W / 8,
  localparam int unsigned NB_W   = $clog2(NBYTES + 1),
  localparam int unsigned ACC_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tpl_load_i,
  input  logic [47:0]       tpl_dst_mac_i,
  input  logic [47:0]       tpl_src_mac_i,
  input  logic [31:0]       tpl_src_ip_i,
  input  logic [31:0]       tpl_dst_ip_i,
  input  logic [15:0]       tpl_src_port_i,
  input  logic [15:0]       tpl_dst_port_i,
  input  logic [7:0]        tpl_tos_i,
  input  logic [7:0]        tpl_ttl_i,
  input  logic [31:0]       tpl_seq_i,
  input  logic [15:0]       tpl_ip_id_i,
  input  logic              req_valid_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [31:0]       req_ack_i,
  input  logic [15:0]       req_win_i,
  input  logic [7:0]        req_flags_i,
  input  logic              pay_valid_i,
  input  logic [DATA_W-1:0] pay_data_i,
  output logic              busy_o,
  output logic              pay_ready_o,
  output logic              done_o,
  output logic [HDR_W-1:0]  hdr_o,
  output logic [15:0]       frame_len_o
);
  conn_tpl_t        tpl_q;
  logic [31:0]      seq_q, ack_q;
  logic [15:0]      id_q, win_q;
  logic [7:0]       flags_q, pkt_flags;
  logic             start, take, fire, last, acc_clear;
  logic [NB_W-1:0]  nbytes;
  logic [SEG_W-1:0] seg_len;
  logic [ACC_W-1:0] pay_sum;
  logic [HDR_W-1:0] hdr_c;
  logic [15:0]      flen_c;

  tx_hdr_seg_ctrl #(.LEN_W(LEN_W), .MSS(MSS), .NBYTES(NBYTES)) i_seg_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_len_i, .pay_valid_i,
    .start_o(start), .take_o(take), .fire_o(fire), .last_o(last),
    .acc_clear_o(acc_clear), .nbytes_o(nbytes), .seg_len_o(seg_len),
    .busy_o, .pay_ready_o
  );

  tx_hdr_csum_acc #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_csum_acc (
    .clk_i, .rst_ni,
    .clear_i(acc_clear), .add_i(take), .data_i(pay_data_i),
    .nbytes_i(nbytes), .acc_o(pay_sum)
  );

  // push flag only on the closing segment of a request
  assign pkt_flags = last ? (flags_q | 8'h08) : (flags_q & 8'hF7);

  tx_hdr_build #(.SEG_W(SEG_W)) i_build (
    .tpl_i(tpl_q), .seq_i(seq_q), .ack_i(ack_q), .id_i(id_q),
    .win_i(win_q), .flags_i(pkt_flags), .seg_len_i(seg_len),
    .pay_sum_i(pay_sum), .hdr_o(hdr_c), .frame_len_o(flen_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tpl_q       <= '0;
      seq_q       <= '0;
      id_q        <= '0;
      ack_q       <= '0;
      win_q       <= '0;
      flags_q     <= '0;
      hdr_o       <= '0;
      frame_len_o <= '0;
      done_o      <= 1'b0;
    end else begin
      done_o <= fire;
      if (tpl_load_i && !busy_o) begin
        tpl_q <= '{dst_mac: tpl_dst_mac_i, src_mac: tpl_src_mac_i,
                   src_ip: tpl_src_ip_i, dst_ip: tpl_dst_ip_i,
                   src_port: tpl_src_port_i, dst_port: tpl_dst_port_i,
                   tos: tpl_tos_i, ttl: tpl_ttl_i};
        seq_q <= tpl_seq_i;
        id_q  <= tpl_ip_id_i;
      end
      if (start) begin
        ack_q   <= req_ack_i;
        win_q   <= req_win_i;
        flags_q <= req_flags_i;
      end
      if (fire) begin
        hdr_o       <= hdr_c;
        frame_len_o <= flen_c;
        seq_q       <= seq_q + 32'(seg_len);
        id_q        <= id_q + 16'd1;
      end
    end
  end
endmodule

// File: rtl/tx_hdr_gen_chk.sv
module tx_hdr_gen_chk #(
  parameter int unsigned MSS = 1448
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         req_valid_i,
  input logic         busy_o,
  input logic         pay_ready_o,
  input logic         done_o,
  input logic [15:0]  frame_len_o,
  input logic [431:0] hdr_o
);
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_HDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hdr_o) |-> done_o); // R8
  AST_READY_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_ready_o |-> busy_o); // R10
  AST_BUSY_RISE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i)); // R9
  AST_BUSY_FALL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R9
  AST_FRAME_BOUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (frame_len_o >= 16'd55) && (frame_len_o <= 16'(54 + MSS))); // R4
endmodule

bind tx_hdr_gen tx_hdr_gen_chk #(.MSS(MSS)) i_tx_hdr_gen_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .busy_o(busy_o), .pay_ready_o(pay_ready_o), .done_o(done_o),
  .frame_len_o(frame_len_o), .hdr_o(hdr_o)
);

// File: tb/test_tx_hdr_gen.sv
module test_tx_hdr_gen;
  localparam int MSS = 1448;
  localparam int LEN_W = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic        tpl_load = 0;
  logic [47:0] tpl_dst_mac = 0, tpl_src_mac = 0;
  logic [31:0] tpl_src_ip = 0, tpl_dst_ip = 0, tpl_seq = 0;
  logic [15:0] tpl_src_port = 0, tpl_dst_port = 0, tpl_ip_id = 0;
  logic [7:0]  tpl_tos = 0, tpl_ttl = 0;
  logic        req_valid = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic [31:0] req_ack = 0;
  logic [15:0] req_win = 0;
  logic [7:0]  req_flags = 0;
  logic        pay_valid = 0;
  logic [63:0] pay_data = 0;
  logic        busy_o, pay_ready_o, done_o;
  logic [431:0] hdr_o;
  logic [15:0] frame_len_o;

  tx_hdr_gen #(.MSS(MSS), .LEN_W(LEN_W)) i_tx_hdr_gen (
    .clk_i(clk), .rst_ni(rst_ni), .tpl_load_i(tpl_load),
    .tpl_dst_mac_i(tpl_dst_mac), .tpl_src_mac_i(tpl_src_mac),
    .tpl_src_ip_i(tpl_src_ip), .tpl_dst_ip_i(tpl_dst_ip),
    .tpl_src_port_i(tpl_src_port), .tpl_dst_port_i(tpl_dst_port),
    .tpl_tos_i(tpl_tos), .tpl_ttl_i(tpl_ttl), .tpl_seq_i(tpl_seq),
    .tpl_ip_id_i(tpl_ip_id), .req_valid_i(req_valid), .req_len_i(req_len),
    .req_ack_i(req_ack), .req_win_i(req_win), .req_flags_i(req_flags),
    .pay_valid_i(pay_valid), .pay_data_i(pay_data), .busy_o(busy_o),
    .pay_ready_o(pay_ready_o), .done_o(done_o), .hdr_o(hdr_o),
    .frame_len_o(frame_len_o)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  // reference model state
  logic [47:0] m_dst_mac, m_src_mac;
  logic [31:0] m_sip, m_dip, m_seq, r_ack;
  logic [15:0] m_sp, m_dp, m_id, r_win;
  logic [7:0]  m_tos, m_ttl, r_flags;
  logic [7:0]  seg_b [0:2047];
  int          seg_n;

  task automatic chk(input bit ok, input string tag, input logic [431:0] act, input logic [431:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int add16(input int a, input int v);
    int t;
    t = a + v;
    if (t > 65535) t = t - 65535;
    return t;
  endfunction

  function automatic logic [7:0] pbyte(input int i, input int seed);
    return 8'((i * 37 + seed * 11 + (i >> 3)) & 255);
  endfunction

  function automatic logic [431:0] exp_hdr(input bit last);
    logic [7:0]  hb [0:53];
    logic [431:0] e;
    logic [15:0] tot, ck;
    logic [7:0]  fl;
    int s;
    fl  = last ? (r_flags | 8'h08) : (r_flags & 8'hF7);
    tot = 16'(40 + seg_n);
    for (int i = 0; i < 6; i++) begin
      hb[i]     = m_dst_mac[47-8*i -: 8];
      hb[6+i]   = m_src_mac[47-8*i -: 8];
    end
    hb[12] = 8'h08; hb[13] = 8'h00;
    hb[14] = 8'h45; hb[15] = m_tos; hb[16] = tot[15:8]; hb[17] = tot[7:0];
    hb[18] = m_id[15:8]; hb[19] = m_id[7:0]; hb[20] = 8'h40; hb[21] = 8'h00;
    hb[22] = m_ttl; hb[23] = 8'h06; hb[24] = 8'h00; hb[25] = 8'h00;
    for (int i = 0; i < 4; i++) begin
      hb[26+i] = m_sip[31-8*i -: 8];
      hb[30+i] = m_dip[31-8*i -: 8];
      hb[38+i] = m_seq[31-8*i -: 8];
      hb[42+i] = r_ack[31-8*i -: 8];
    end
    hb[34] = m_sp[15:8]; hb[35] = m_sp[7:0]; hb[36] = m_dp[15:8]; hb[37] = m_dp[7:0];
    hb[46] = 8'h50; hb[47] = fl; hb[48] = r_win[15:8]; hb[49] = r_win[7:0];
    hb[50] = 8'h00; hb[51] = 8'h00; hb[52] = 8'h00; hb[53] = 8'h00;
    s = 0;
    for (int i = 14; i < 34; i += 2) s = add16(s, int'({hb[i], hb[i+1]}));
    ck = ~16'(s);
    hb[24] = ck[15:8]; hb[25] = ck[7:0];
    s = 0;
    for (int i = 26; i < 34; i += 2) s = add16(s, int'({hb[i], hb[i+1]}));
    s = add16(s, 6);
    s = add16(s, 20 + seg_n);
    for (int i = 34; i < 54; i += 2) s = add16(s, int'({hb[i], hb[i+1]}));
    for (int j = 0; j < seg_n; j += 2)
      s = add16(s, int'({seg_b[j], (j + 1 < seg_n) ? seg_b[j+1] : 8'h00}));
    ck = ~16'(s);
    hb[50] = ck[15:8]; hb[51] = ck[7:0];
    for (int i = 0; i < 54; i++) e[431-8*i -: 8] = hb[i];
    return e;
  endfunction

  task automatic load_tpl(input logic [47:0] dm, input logic [47:0] sm, input logic [31:0] si,
                          input logic [31:0] di, input logic [15:0] sp, input logic [15:0] dp,
                          input logic [7:0] tos, input logic [7:0] ttl,
                          input logic [31:0] seq, input logic [15:0] id);
    tpl_dst_mac = dm; tpl_src_mac = sm; tpl_src_ip = si; tpl_dst_ip = di;
    tpl_src_port = sp; tpl_dst_port = dp; tpl_tos = tos; tpl_ttl = ttl;
    tpl_seq = seq; tpl_ip_id = id; tpl_load = 1;
    @(negedge clk);
    tpl_load = 0;
    m_dst_mac = dm; m_src_mac = sm; m_sip = si; m_dip = di; m_sp = sp; m_dp = dp;
    m_tos = tos; m_ttl = ttl; m_seq = seq; m_id = id;
  endtask

  task automatic send_req(input int len, input logic [31:0] ack, input logic [15:0] win,
                          input logic [7:0] fl, input int seed, input bit gap, input bit disturb);
    int off, rem, seg, nw;
    logic [63:0] w;
    logic [431:0] e;
    r_ack = ack; r_win = win; r_flags = fl;
    req_valid = 1; req_len = LEN_W'(len); req_ack = ack; req_win = win; req_flags = fl;
    @(negedge clk);
    req_valid = 0;
    chk(busy_o == 1'b1, "R9 busy after accept", 432'(busy_o), 432'(1));
    off = 0; rem = len;
    while (rem > 0) begin
      seg = (rem > MSS) ? MSS : rem;
      seg_n = seg;
      for (int j = 0; j < seg; j++) seg_b[j] = pbyte(off + j, seed);
      nw = (seg + 7) / 8;
      for (int k = 0; k < nw; k++) begin
        if (gap && k == 1) begin
          pay_valid = 0; pay_data = 64'hFFFF_FFFF_FFFF_FFFF;
          @(negedge clk);
          chk(pay_ready_o == 1'b1, "R10 ready held over gap", 432'(pay_ready_o), 432'(1));
        end
        for (int b = 0; b < 8; b++)
          w[63-8*b -: 8] = (k * 8 + b < seg) ? seg_b[k*8+b] : 8'hA5;
        pay_valid = 1; pay_data = w;
        if (disturb && off > 0 && k == 0) begin
          tpl_load = 1; tpl_dst_mac = 48'hDEAD_BEEF_0001; tpl_seq = 32'h1234_5678;
          req_valid = 1; req_len = LEN_W'(5);
        end
        @(negedge clk);
        tpl_load = 0; req_valid = 0;
      end
      pay_valid = 0;
      chk(done_o == 1'b0, "R8 done not before finish cycle", 432'(done_o), 432'(0));
      chk(pay_ready_o == 1'b0, "R10 ready low after last word", 432'(pay_ready_o), 432'(0));
      @(negedge clk);
      rem = rem - seg;
      e = exp_hdr(rem == 0);
      chk(done_o == 1'b1, "R8 done pulse", 432'(done_o), 432'(1));
      chk(hdr_o[431:272] == e[431:272], "R1 template fields", 432'(hdr_o[431:272]), 432'(e[431:272]));
      chk(hdr_o[287:272] == e[287:272] && hdr_o[127:96] == e[127:96], "R3 id and seq",
          432'({hdr_o[287:272], hdr_o[127:96]}), 432'({e[287:272], e[127:96]}));
      chk(hdr_o[239:224] == e[239:224], "R6 ip checksum", 432'(hdr_o[239:224]), 432'(e[239:224]));
      chk(hdr_o[31:16] == e[31:16], "R5 tcp checksum", 432'(hdr_o[31:16]), 432'(e[31:16]));
      chk(hdr_o[55:48] == e[55:48], "R7 flags", 432'(hdr_o[55:48]), 432'(e[55:48]));
      chk(hdr_o == e, "R11 whole header", hdr_o, e);
      chk(frame_len_o == 16'(54 + seg), "R4 frame length", 432'(frame_len_o), 432'(54 + seg));
      chk(busy_o == (rem > 0), "R9 busy vs remaining", 432'(busy_o), 432'(rem > 0));
      m_seq = m_seq + 32'(seg); m_id = m_id + 16'd1; off = off + seg;
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R8 single cycle pulse", 432'(done_o), 432'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && pay_ready_o == 0, "R8 reset outputs",
        432'({busy_o, done_o, pay_ready_o}), 432'(0));
    chk(hdr_o == '0 && frame_len_o == 0, "R8 reset header", hdr_o, 432'(0));
    rst_ni = 1;
    @(negedge clk);
    // stray payload while idle must not reach a checksum
    pay_valid = 1; pay_data = 64'h1357_9BDF_2468_ACE0;
    @(negedge clk);
    chk(pay_ready_o == 1'b0, "R10 no ready when idle", 432'(pay_ready_o), 432'(0));
    @(negedge clk);
    pay_valid = 0;
    load_tpl(48'h0011_2233_4455, 48'h6677_8899_AABB, 32'hC0A8_0001, 32'hC0A8_0002,
             16'd5001, 16'd80, 8'h10, 8'd64, 32'hFFFF_FF00, 16'hFFFF);
    // zero length request
    req_valid = 1; req_len = 0;
    @(negedge clk);
    req_valid = 0;
    chk(busy_o == 1'b0, "R2 zero length ignored", 432'(busy_o), 432'(0));
    @(negedge clk);
    send_req(101, 32'hA000_0001, 16'd8192, 8'h10, 1, 1, 0);   // R5 odd, R3 wrap
    send_req(3000, 32'hA000_1000, 16'd4096, 8'h18, 2, 0, 1);  // R2 R7 R1 R9
    send_req(1448, 32'h0000_0042, 16'd65535, 8'h10, 3, 0, 0); // R2 boundary
    send_req(1449, 32'h0BAD_F00D, 16'd1, 8'h11, 4, 1, 0);     // R2 one-byte tail
    load_tpl(48'hFEDC_BA98_7654, 48'h0102_0304_0506, 32'h0A00_0005, 32'h0A00_0009,
             16'd443, 16'd33000, 8'h00, 8'd255, 32'h0000_0010, 16'h0100);
    send_req(64, 32'h1111_2222, 16'd300, 8'h00, 5, 0, 0);    // R1 reload
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule